// File: doc/BRIEF.md
# Victim Line Buffer

This block is a tiny fully associative store of whole cache lines, placed on the refill path of a direct-mapped first-level cache. Every first-level miss is presented to it as a single lookup. The lookup carries two things: the line address being requested, and (optionally) the line the first-level cache is about to throw out to make room. All stored line addresses are compared with the requested address in the same cycle. The outcome comes back one cycle after the lookup is accepted.

On a hit, the stored line is handed back to the first-level cache together with its dirty flag. The outgoing first-level line drops into the slot the hit line just vacated, so the two lines trade places in one step. On a miss, a refill request for the requested address goes to the next memory level. The outgoing first-level line is kept here, and the requested line is never stored. When the store is full, the least recently used entry makes way. If that entry is dirty, it leaves on a writeback handshake.

Top module: `victim_buffer`

## Requirements
- R1: A synchronous reset empties every entry and drops `rsp_valid`, `rf_valid` and `wb_valid`. `lk_ready` is high after reset, and any lookup after reset misses until something has been stored.
- R2: A lookup accepted on a clock edge (`lk_valid` and `lk_ready` both high) raises `rsp_valid` for exactly the following cycle. `rsp_hit` is high in that cycle only when a valid entry holds a line address equal to `lk_addr` in all bits.
- R3: On a hit, `rsp_data` and `rsp_dirty` carry the data and the dirty flag that were stored with the matching line.
- R4: On a hit, the line leaves the buffer. The victim sent with the lookup, if any, takes its slot. With no victim, the slot becomes free.
- R5: On a miss, `rf_valid` rises in the response cycle with `rf_addr` equal to the requested address, and stays asserted, unchanged, until `rf_ready` is seen. The requested line is not stored.
- R6: On a miss, the victim sent with the lookup (if `vin_valid`) is stored with its address, data and dirty flag, and a later lookup of it hits.
- R7: A stored victim goes to the lowest-numbered free entry. When no entry is free, it replaces the entry least recently written (by a miss insert or a hit swap).
- R8: When a miss insert replaces a valid dirty entry, `wb_valid` rises in the response cycle carrying that entry's address and data, and holds until `wb_ready`. Replacing a clean entry raises no writeback.
- R9: `lk_ready` is low while a refill request or a writeback is outstanding, and a lookup offered then is not answered.
- R10: A hit raises no refill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | ADDR_W | Requested line address |
| vin_valid | input | 1 | A victim line accompanies the lookup |
| vin_addr | input | ADDR_W | Victim line address |
| vin_data | input | DATA_W | Victim line data |
| vin_dirty | input | 1 | Victim line is modified |
| rsp_valid | output | 1 | Lookup result valid (one cycle) |
| rsp_hit | output | 1 | Requested line was found |
| rsp_data | output | DATA_W | Data of the found line |
| rsp_dirty | output | 1 | Dirty flag of the found line |
| rf_valid | output | 1 | Refill request to the next level |
| rf_ready | input | 1 | Next level takes the refill request |
| rf_addr | output | ADDR_W | Line address to refill |
| wb_valid | output | 1 | Dirty replaced line offered for writeback |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
Addresses that differ from a stored line only in the top bit or the bottom bit are looked up. A compare that ignores some address bits would report false hits on them.

After a hit swap, and after a hit with no victim, the old line is looked up again. A design that copied instead of swapping, or that left the slot valid, would hit where it must miss.

The buffer is overfilled with mixed clean and dirty victims under a random sequence checked against a recency-list model. A wrong replacement choice shows up as a wrong hit, a wrong writeback address, or a writeback for a clean line.

Lookups are offered while a refill is still pending and the ready inputs are held low for random stretches. This catches a design that answers a blocked lookup or drops or changes a request before its handshake.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Index width for a count of entries; never zero.
  function automatic int unsigned vc_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Recency step for one entry when slot `ref_age` is touched.
  // The touched entry becomes youngest (0); entries younger than it age by one.
  function automatic logic [7:0] vc_age_next(input logic [7:0] cur,
                                             input logic [7:0] ref_age,
                                             input logic       is_self);
    if (is_self)            return 8'd0;
    else if (cur < ref_age) return cur + 8'd1;
    else                    return cur;
  endfunction

  // A miss that stores a victim over a valid dirty entry must spill it.
  function automatic logic vc_spill(input logic miss, input logic vin,
                                    input logic old_valid, input logic old_dirty);
    return miss & vin & old_valid & old_dirty;
  endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0]              valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  tags,
  input  logic [ADDR_W-1:0]               addr,
  output logic                            hit,
  output logic [IDX_W-1:0]                hit_idx
);

  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == addr);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  // R2: at most one entry can claim a line address
  p_match_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

endmodule

// File: rtl/vc_lru.sv
module vc_lru
  import vc_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   repl_idx
);

  logic [ENTRIES-1:0][IDX_W-1:0] age;
  logic                          any_free;

  assign any_free = ~&valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++)
        age[i] <= IDX_W'(vc_age_next(8'(age[i]), 8'(age[touch_idx]),
                                     touch_idx == IDX_W'(i)));
    end
  end

  always_comb begin
    repl_idx = '0;
    if (any_free) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!valid[i]) repl_idx = IDX_W'(i);
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (age[i] == IDX_W'(ENTRIES - 1)) repl_idx = IDX_W'(i);
    end
  end

  // R7: ages remain a permutation, so exactly one entry is oldest
  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        p_age_range_r7: assert (age[i] <= IDX_W'(ENTRIES - 1))
          else $error("age out of range");
        for (int j = i + 1; j < ENTRIES; j++)
          p_age_unique_r7: assert (age[i] != age[j])
            else $error("duplicate age");
      end
    end
  end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              vin_valid,
  input  logic [ADDR_W-1:0] vin_addr,
  input  logic [DATA_W-1:0] vin_data,
  input  logic              vin_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              rf_valid,
  input  logic              rf_ready,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  localparam int unsigned IDX_W = vc_idx_w(ENTRIES);

  // Entry storage
  logic [ENTRIES-1:0]             e_valid;
  logic [ENTRIES-1:0]             e_dirty;
  logic [ENTRIES-1:0][ADDR_W-1:0] e_tag;
  logic [ENTRIES-1:0][DATA_W-1:0] e_data;

  // Named internal events
  logic             lk_fire;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] repl_idx;
  logic [IDX_W-1:0] slot;
  logic             spill_dirty;
  logic             touch;
  logic             rf_pend, wb_pend;
  logic [ADDR_W-1:0] rf_addr_q, wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;

  vc_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .valid   (e_valid),
    .tags    (e_tag),
    .addr    (lk_addr),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  vc_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch     (touch),
    .touch_idx (slot),
    .valid     (e_valid),
    .repl_idx  (repl_idx)
  );

  assign lk_ready    = !rf_pend && !wb_pend;
  assign lk_fire     = lk_valid && lk_ready;
  assign slot        = hit ? hit_idx : repl_idx;
  assign touch       = lk_fire && vin_valid;
  assign spill_dirty = lk_fire &&
                       vc_spill(!hit, vin_valid, e_valid[repl_idx], e_dirty[repl_idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid   <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rf_pend   <= 1'b0;
      wb_pend   <= 1'b0;
    end else begin
      rsp_valid <= lk_fire;
      if (rf_pend && rf_ready) rf_pend <= 1'b0;
      if (wb_pend && wb_ready) wb_pend <= 1'b0;
      if (lk_fire) begin
        rsp_hit <= hit;
        if (hit) begin
          rsp_data  <= e_data[hit_idx];
          rsp_dirty <= e_dirty[hit_idx];
        end else begin
          rf_pend   <= 1'b1;
          rf_addr_q <= lk_addr;
        end
        if (spill_dirty) begin
          wb_pend   <= 1'b1;
          wb_addr_q <= e_tag[repl_idx];
          wb_data_q <= e_data[repl_idx];
        end
        if (vin_valid) begin
          e_valid[slot] <= 1'b1;
          e_dirty[slot] <= vin_dirty;
          e_tag[slot]   <= vin_addr;
          e_data[slot]  <= vin_data;
        end else if (hit) begin
          e_valid[hit_idx] <= 1'b0;
        end
      end
    end
  end

  assign rf_valid = rf_pend;
  assign rf_addr  = rf_addr_q;
  assign wb_valid = wb_pend;
  assign wb_addr  = wb_addr_q;
  assign wb_data  = wb_data_q;

  // R2: response one cycle after acceptance, and never otherwise
  p_rsp_after_fire_r2: assert property (@(posedge clk) disable iff (rst)
    lk_fire |=> rsp_valid);
  p_rsp_only_fire_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_fire |=> !rsp_valid);
  // R5: a miss raises a refill that holds steady until taken
  p_miss_refill_r5: assert property (@(posedge clk) disable iff (rst)
    (lk_fire && !hit) |=> rf_valid);
  p_rf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (rf_valid && !rf_ready) |=> (rf_valid && $stable(rf_addr)));
  // R10: a hit raises no refill
  p_hit_norefill_r10: assert property (@(posedge clk) disable iff (rst)
    (lk_fire && hit) |=> !rf_valid);
  // R8: dirty spill offered next cycle and held until accepted
  p_spill_wb_r8: assert property (@(posedge clk) disable iff (rst)
    spill_dirty |=> wb_valid);
  p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
  // R9: no acceptance while anything is outstanding
  p_block_r9: assert property (@(posedge clk) disable iff (rst)
    (rf_valid || wb_valid) |-> !lk_ready);
  // R6: a stored victim is valid afterwards
  p_store_r6: assert property (@(posedge clk) disable iff (rst)
    touch |=> e_valid[$past(slot)]);

endmodule

// File: tb/test_victim_buffer.sv
module test_victim_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;
  localparam int DW = 64;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          lk_valid, lk_ready;
  logic [AW-1:0] lk_addr;
  logic          vin_valid, vin_dirty;
  logic [AW-1:0] vin_addr;
  logic [DW-1:0] vin_data;
  logic          rsp_valid, rsp_hit, rsp_dirty;
  logic [DW-1:0] rsp_data;
  logic          rf_valid, rf_ready;
  logic [AW-1:0] rf_addr;
  logic          wb_valid, wb_ready;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  int checks = 0;
  int fails  = 0;

  // Bench model: slots plus a recency list (index 0 = most recent)
  logic          m_valid [NE];
  logic          m_dirty [NE];
  logic [AW-1:0] m_addr  [NE];
  logic [DW-1:0] m_data  [NE];
  int            m_order [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_buffer #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE)) i_victim_buffer (
    .clk, .rst, .lk_valid, .lk_ready, .lk_addr, .vin_valid, .vin_addr,
    .vin_data, .vin_dirty, .rsp_valid, .rsp_hit, .rsp_data, .rsp_dirty,
    .rf_valid, .rf_ready, .rf_addr, .wb_valid, .wb_ready, .wb_addr, .wb_data
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) if (m_valid[i] && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_pick();
    for (int i = 0; i < NE; i++) if (!m_valid[i]) return i;
    return m_order[NE-1];
  endfunction

  function automatic void m_touch(input int s);
    int p = 0;
    for (int k = 0; k < NE; k++) if (m_order[k] == s) p = k;
    for (int k = p; k > 0; k--) m_order[k] = m_order[k-1];
    m_order[0] = s;
  endfunction

  task automatic lookup(input string tag, input logic [AW-1:0] a, input bit vv,
                        input logic [AW-1:0] va, input logic [DW-1:0] vd,
                        input bit vdirty, input bit try_blocked);
    int  s    = m_find(a);
    bit  eh   = (s >= 0);
    int  slot = eh ? s : m_pick();
    bit  ewb  = !eh && vv && m_valid[slot] && m_dirty[slot];
    logic [AW-1:0] ewa = m_addr[slot];
    logic [DW-1:0] ewd = m_data[slot];
    int  n = 0;
    @(negedge clk);
    chk("R9", "ready before lookup", 64'(lk_ready), 64'd1);
    lk_valid = 1'b1; lk_addr = a;
    vin_valid = vv; vin_addr = va; vin_data = vd; vin_dirty = vdirty;
    @(negedge clk);
    lk_valid = 1'b0; vin_valid = 1'b0;
    chk("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(tag, "rsp_hit", 64'(rsp_hit), 64'(eh));
    if (eh) begin
      chk("R3", "rsp_data", rsp_data, m_data[s]);
      chk("R3", "rsp_dirty", 64'(rsp_dirty), 64'(m_dirty[s]));
    end
    chk(eh ? "R10" : "R5", "rf_valid", 64'(rf_valid), 64'(!eh));
    if (!eh) chk("R5", "rf_addr", 64'(rf_addr), 64'(a));
    chk("R8", "wb_valid", 64'(wb_valid), 64'(ewb));
    if (ewb) begin
      chk("R8", "wb_addr", 64'(wb_addr), 64'(ewa));
      chk("R8", "wb_data", wb_data, ewd);
    end
    // model update
    if (vv) begin
      m_valid[slot] = 1'b1; m_addr[slot] = va;
      m_data[slot] = vd; m_dirty[slot] = vdirty;
      m_touch(slot);
    end else if (eh) begin
      m_valid[s] = 1'b0;
    end
    if (rf_valid || wb_valid) chk("R9", "lk_ready while pending", 64'(lk_ready), 64'd0);
    if (try_blocked && rf_valid) begin
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
      chk("R9", "blocked lookup answered", 64'(rsp_valid), 64'd0);
      chk("R5", "rf held", 64'(rf_valid), 64'd1);
    end else begin
      @(negedge clk);
      chk("R2", "rsp_valid one cycle", 64'(rsp_valid), 64'd0);
    end
    while ((rf_valid || wb_valid) && n < 20) begin
      rf_ready = (n > 3) || ($urandom % 2 == 0);
      wb_ready = (n > 3) || ($urandom % 2 == 0);
      @(negedge clk);
      rf_ready = 1'b0; wb_ready = 1'b0;
      n++;
    end
    chk("R5", "refill drained", 64'(rf_valid), 64'd0);
    chk("R8", "writeback drained", 64'(wb_valid), 64'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [AW-1:0] xa;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NE; i++) begin
      m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_addr[i] = '0; m_data[i] = '0;
      m_order[i] = i;
    end
    rst = 1'b1; lk_valid = 1'b0; lk_addr = '0; vin_valid = 1'b0;
    vin_addr = '0; vin_data = '0; vin_dirty = 1'b0; rf_ready = 1'b0; wb_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "lk_ready", 64'(lk_ready), 64'd1);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "rf_valid", 64'(rf_valid), 64'd0);
    chk("R1", "wb_valid", 64'(wb_valid), 64'd0);

    // Directed: empty miss stores victim, swap on hit, removal, no requested store
    lookup("R1", 28'h0001000, 1, 28'h0001001, 64'hB0B0_0001, 1, 1);
    lookup("R6", 28'h0001001, 1, 28'h0001002, 64'hC0C0_0002, 0, 0);
    lookup("R4", 28'h0001001, 0, '0, '0, 0, 0);
    lookup("R4", 28'h0001002, 0, '0, '0, 0, 0);
    lookup("R5", 28'h0001000, 0, '0, '0, 0, 0);
    // Full-address compare
    xa = 28'h0005A5A;
    lookup("R6", 28'h0001000, 1, xa, 64'h1234_5678_9ABC_DEF0, 1, 0);
    lookup("R2", xa ^ 28'h8000000, 0, '0, '0, 0, 0);
    lookup("R2", xa ^ 28'h0000001, 0, '0, '0, 0, 0);
    // Overfill with mixed dirty/clean victims
    for (int k = 0; k < 7; k++)
      lookup("R7", 28'h0003000 + 28'(k), 1, 28'h0004000 + 28'(k),
             {32'hD00D_0000, 32'(k)}, (k % 2 == 0), (k == 3));
    for (int k = 0; k < 7; k++)
      lookup("R7", 28'h0004000 + 28'(k), 0, '0, '0, 0, 0);

    // Random traffic over a small address pool
    for (int t = 0; t < 400; t++) begin
      logic [AW-1:0] a = 28'h0002000 + 28'($urandom % 9);
      logic [AW-1:0] va = '0;
      bit vv = 1'b0;
      if ($urandom % 5 != 0) begin
        for (int tries = 0; tries < 10 && !vv; tries++) begin
          va = 28'h0002000 + 28'($urandom % 9);
          if (va != a && m_find(va) < 0) vv = 1'b1;
        end
      end
      lookup("R2", a, vv, va, {$urandom, $urandom}, ($urandom % 2 == 0),
             ($urandom % 4 == 0));
    end
    finish_run();
  end

endmodule